// File: doc/BRIEF.md
# Converter Serial Result Port

This block is the digital output side of a 20-bit sampling converter. Each finished conversion arrives as a parallel two's-complement word with a one-cycle strobe. The block copies that word, one bit at a time and MSB first, into a data output register. It then serves the register to a host over a serial link. The host provides an asynchronous chip select and serial clock. The block returns one data bit per serial clock rising edge, plus an output-enable that the pad logic uses to tri-state the data line.

An active-low ready line tells the host that a new result can be fetched. Its waveform depends on how the host uses chip select, which a static strap input selects:

- **Select tied low:** the line idles high and gives a fixed-length low pulse after each register update.
- **Select used per transfer:** the line falls when the update finishes. It stays low until select has been low for a fixed time.
- **Select parked high:** the line idles low. It rises when a new result starts to load, and falls a fixed time after the load ends.

The read pointer returns to the MSB each time an update completes, so partial reads are harmless. Reads longer than the word return zeros. A flag marks results as trustworthy only from the sixth completed conversion after reset.

Top module: `adc_result_port`

## Requirements
- R1: Each result is `RES_W` (20) bits in two's complement, for example 7FFFFh, 00000h and 80000h. The n-th synchronized serial clock rising edge while selected drives result bit `RES_W-n` on `dout`. `RES_W` edges therefore return the whole word, MSB first.
- R2: `dout_oe` is high exactly when `cs_n`, seen through a two-flop synchronizer, is low, so it follows `cs_n` two clock cycles late.
- R3: Serial clock edges beyond the `RES_W`-th drive `dout` low. A 24-edge read ends in four zero bits.
- R4: Completing a register update returns the read pointer to the MSB. A read that stopped after 8 or 16 bits, followed by a new result, makes the next read start with the new MSB. A read left incomplete does not block the update.
- R5: The register update writes one bit every `WR_STEP` cycles, MSB first, over `RES_W*WR_STEP` cycles. `drdy_n` is high throughout the update and first goes low `RES_W*WR_STEP+1` cycles after the cycle in which the strobe is sampled.
- R6: With `cs_mode` = 0 (select tied low), `drdy_n` idles high and pulses low for exactly `PULSE_CYC` cycles after each update.
- R7: With `cs_mode` = 1 (select used per transfer), `drdy_n` goes low after the update and stays low while `cs_n` stays high. After `cs_n` falls, `drdy_n` stays low for the two synchronizer cycles, one cycle of recognition and `PULSE_CYC` cycles, and then returns high.
- R8: With `cs_mode` = 2 (select parked high), `drdy_n` idles low. It rises in the cycle after the strobe is sampled, stays high through the update and for `HOLD_CYC` further cycles, then falls.
- R9: `result_ok` stays low for the first `WARMUP` (5) completed updates after reset. It goes high when the sixth update completes and stays high.
- R10: Reset sets `drdy_n` to its idle level (high for `cs_mode` 0 and 1, low for 2) and sets `dout` and `result_ok` low. `dout_oe` is low while `cs_n` is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_mode | input | 2 | Strap: 0 select tied low, 1 select used per transfer, 2 select parked high |
| res_strobe | input | 1 | One-cycle pulse marking a new conversion result |
| res_word | input | RES_W | Conversion result, two's complement |
| cs_n | input | 1 | Asynchronous active-low chip select from the host |
| sclk | input | 1 | Asynchronous serial clock from the host |
| dout | output | 1 | Serial data, changes after a synchronized rising edge of `sclk` |
| dout_oe | output | 1 | Drive enable for the serial data pad |
| drdy_n | output | 1 | Active-low data-ready indication |
| result_ok | output | 1 | High once the warm-up results have been discarded |

## Verification
The bench measures the ready waveform cycle by cycle in each select mode:

- **Tied low:** it counts the delay and the width of the low pulse. A design that starts the pulse before the update ends, or miscounts the pulse, shows a wrong delay or width.
- **Used per transfer:** it keeps select high for a long time and then counts the release after select falls. A design that releases on a timer alone, or ignores the synchronizer delay, is caught.
- **Parked high:** it checks the inverted idle level and the length of the high window.

Partial reads of 8 and 16 bits followed by a new result expose a pointer that fails to re-arm, which would return stale low-order bits. A 24-bit read exposes a pointer that wraps instead of padding. The extreme codes 7FFFFh and 80000h expose bit-order or sign errors. The warm-up flag is checked after every one of six results, which catches an off-by-one in the discard count.

// File: rtl/adcp_pkg.sv
// Shared types for the converter serial result port.
package adcp_pkg;

    // How the host uses chip select; chosen by a static strap.
    typedef enum logic [1:0] {
        CSM_TIED_LOW    = 2'd0,
        CSM_FRAMED      = 2'd1,
        CSM_PARKED_HIGH = 2'd2
    } cs_mode_e;

    // States of the ready-line sequencer.
    typedef enum logic [1:0] {
        RDY_IDLE,
        RDY_WRITE,
        RDY_WAIT_CS,
        RDY_TIMED
    } rdy_state_e;

endpackage

// File: rtl/adcp_sync.sv
// Multi-bit, multi-stage synchronizer for independent asynchronous inputs.
// Assumes each bit is a level signal that is stable for several clocks;
// no coherence between bits is implied. STAGES must be at least 2.
module adcp_sync #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    // Shift the asynchronous inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg <= {stg[STAGES-2:0], d};
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/adcp_dor_writer.sv
// Captures a result word on its strobe and copies it into the data output
// register one bit every WR_STEP cycles, MSB first. A new strobe restarts
// the copy; reads are never blocked. Also counts completed copies to
// mark the warm-up results. Assumes WR_STEP >= 1.
module adcp_dor_writer #(
    parameter int RES_W   = 20,
    parameter int WR_STEP = 2,
    parameter int WARMUP  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RES_W-1:0] load_word,
    output logic [RES_W-1:0] dor,
    output logic             busy,
    output logic             done,
    output logic             ok
);

    localparam int IDX_W  = (RES_W > 1) ? $clog2(RES_W) : 1;
    localparam int STEP_W = $clog2(WR_STEP + 1);
    localparam int CNT_W  = $clog2(WARMUP + 2);

    logic [RES_W-1:0]  stage;
    logic [IDX_W-1:0]  idx;
    logic [STEP_W-1:0] step;
    logic [CNT_W-1:0]  n_done;

    // Walk the staged word into the output register, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= '0;
            dor   <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
            idx   <= '0;
            step  <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                stage <= load_word;
                busy  <= 1'b1;
                idx   <= IDX_W'(RES_W - 1);
                step  <= '0;
            end else if (busy) begin
                dor[idx] <= stage[idx];
                if (step == STEP_W'(WR_STEP - 1)) begin
                    step <= '0;
                    if (idx == '0) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        idx <= idx - 1'b1;
                    end
                end else begin
                    step <= step + 1'b1;
                end
            end
        end
    end

    // Count finished copies, saturating once warm-up is over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_done <= '0;
        end else if (busy && !load && step == STEP_W'(WR_STEP - 1) && idx == '0
                     && n_done != CNT_W'(WARMUP + 1)) begin
            n_done <= n_done + 1'b1;
        end
    end

    assign ok = (n_done > CNT_W'(WARMUP));

endmodule

// File: rtl/adcp_shift_out.sv
// Serial read-out of the data output register. On each synchronized
// serial clock rising edge while selected, drives the next bit MSB first,
// then zeros once the word is exhausted. The pointer re-arms to the MSB
// whenever a register update completes. Assumes sclk_s is already
// synchronized to clk.
module adcp_shift_out #(
    parameter int RES_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RES_W-1:0] dor,
    input  logic             rearm,
    input  logic             sel,
    input  logic             sclk_s,
    output logic             dout
);

    localparam int PTR_W = $clog2(RES_W + 1);
    localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;

    logic             sclk_d;
    logic             sclk_rise;
    logic [PTR_W-1:0] ptr;
    logic [RES_W-1:0] msb_first;

    // Reorder the register so that index 0 is the MSB.
    for (genvar g = 0; g < RES_W; g++) begin : g_order
        assign msb_first[g] = dor[RES_W-1-g];
    end

    // Delay the synchronized serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    assign sclk_rise = sclk_s & ~sclk_d;

    // Advance the pointer and present the next bit or a pad zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr  <= '0;
            dout <= 1'b0;
        end else if (rearm) begin
            ptr <= '0;
        end else if (sclk_rise && sel) begin
            if (ptr < PTR_W'(RES_W)) begin
                dout <= msb_first[ptr[IDX_W-1:0]];
                ptr  <= ptr + 1'b1;
            end else begin
                dout <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/adcp_ready_gen.sv
// Sequencer for the active-low ready line. Its waveform is chosen by the
// chip-select usage strap: a timed low pulse, a low level held until
// select has been low for a time, or an inverted idle level with a timed
// high window. A new result always forces the line high.
// Assumes PULSE_CYC >= 1 and HOLD_CYC >= 1, and that mode changes only in reset.
module adcp_ready_gen
    import adcp_pkg::*;
#(
    parameter int PULSE_CYC = 8,
    parameter int HOLD_CYC  = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       start,
    input  logic       done,
    input  logic       sel,
    output logic       drdy_n
);

    localparam int MAXC  = (PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    cs_mode_e   mode_e;
    rdy_state_e st;
    logic [CNT_W-1:0] cnt;
    logic       idle_lvl;

    assign mode_e   = cs_mode_e'(mode);
    assign idle_lvl = (mode_e != CSM_PARKED_HIGH);

    // Step the ready sequence through write, wait and timed phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= RDY_IDLE;
            cnt    <= '0;
            drdy_n <= idle_lvl;
        end else if (start) begin
            st     <= RDY_WRITE;
            drdy_n <= 1'b1;
        end else begin
            case (st)
                RDY_WRITE: begin
                    if (done) begin
                        case (mode_e)
                            CSM_FRAMED: begin
                                st     <= RDY_WAIT_CS;
                                drdy_n <= 1'b0;
                            end
                            CSM_PARKED_HIGH: begin
                                st     <= RDY_TIMED;
                                cnt    <= CNT_W'(HOLD_CYC - 1);
                                drdy_n <= 1'b1;
                            end
                            default: begin
                                st     <= RDY_TIMED;
                                cnt    <= CNT_W'(PULSE_CYC - 1);
                                drdy_n <= 1'b0;
                            end
                        endcase
                    end
                end
                RDY_WAIT_CS: begin
                    if (sel) begin
                        st  <= RDY_TIMED;
                        cnt <= CNT_W'(PULSE_CYC - 1);
                    end
                end
                RDY_TIMED: begin
                    if (cnt == '0) begin
                        st     <= RDY_IDLE;
                        drdy_n <= idle_lvl;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    drdy_n <= idle_lvl;
                end
            endcase
        end
    end

endmodule

// File: rtl/adc_result_port.sv
// Top of the converter serial result port. Synchronizes the host's select
// and serial clock, loads each result into the data output register,
// shifts it out and drives the ready line. Assumes the host serial clock
// high and low phases each last at least three system clocks.
module adc_result_port #(
    parameter int RES_W     = 20,
    parameter int WR_STEP   = 2,
    parameter int PULSE_CYC = 8,
    parameter int HOLD_CYC  = 6,
    parameter int WARMUP    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cs_mode,
    input  logic             res_strobe,
    input  logic [RES_W-1:0] res_word,
    input  logic             cs_n,
    input  logic             sclk,
    output logic             dout,
    output logic             dout_oe,
    output logic             drdy_n,
    output logic             result_ok
);

    logic [1:0]       host_s;
    logic             sel;
    logic [RES_W-1:0] dor;
    logic             wr_busy;
    logic             wr_done;

    // host_s[1] is select (idle high), host_s[0] is the serial clock.
    adcp_sync #(.W(2), .STAGES(2), .RST_VAL(2'b10)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sclk}),
        .q     (host_s)
    );

    assign sel     = ~host_s[1];
    assign dout_oe = sel;

    adcp_dor_writer #(.RES_W(RES_W), .WR_STEP(WR_STEP), .WARMUP(WARMUP)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (res_strobe),
        .load_word (res_word),
        .dor       (dor),
        .busy      (wr_busy),
        .done      (wr_done),
        .ok        (result_ok)
    );

    adcp_shift_out #(.RES_W(RES_W)) u_so (
        .clk    (clk),
        .rst_n  (rst_n),
        .dor    (dor),
        .rearm  (wr_done),
        .sel    (sel),
        .sclk_s (host_s[0]),
        .dout   (dout)
    );

    adcp_ready_gen #(.PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)) u_rdy (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (cs_mode),
        .start  (res_strobe),
        .done   (wr_done),
        .sel    (sel),
        .drdy_n (drdy_n)
    );

endmodule

// File: rtl/adc_result_port_chk.sv
// Property checker for the converter serial result port, bound to the top.
module adc_result_port_chk #(
    parameter int PULSE_CYC = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cs_mode,
    input logic       res_strobe,
    input logic       cs_n,
    input logic       dout_oe,
    input logic       drdy_n,
    input logic       result_ok,
    input logic       wr_busy
);

    logic [15:0] low_run;
    logic [1:0]  since_rst;

    // Length of the current run of low ready samples.
    always_ff @(posedge clk) begin
        if (!rst_n)              low_run <= '0;
        else if (drdy_n)         low_run <= '0;
        else if (low_run != '1)  low_run <= low_run + 1'b1;
    end

    // Cycles since reset release, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
    end

    p_oe_follows_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (dout_oe == !$past(cs_n, 2)));

    p_ready_high_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_busy |-> drdy_n);

    p_tied_low_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_mode == 2'd0 && !drdy_n) |-> (low_run < 16'(PULSE_CYC)));

    p_tied_low_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_mode == 2'd0 && $rose(drdy_n) && !$past(res_strobe))
            |-> (low_run == 16'(PULSE_CYC)));

    p_framed_min_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_mode == 2'd1 && $rose(drdy_n) && !$past(res_strobe))
            |-> (low_run > 16'(PULSE_CYC)));

    p_parked_rise_on_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_mode == 2'd2 && $rose(drdy_n)) |-> $past(res_strobe));

    p_ok_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        result_ok |=> result_ok);

endmodule

bind adc_result_port adc_result_port_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_mode    (cs_mode),
    .res_strobe (res_strobe),
    .cs_n       (cs_n),
    .dout_oe    (dout_oe),
    .drdy_n     (drdy_n),
    .result_ok  (result_ok),
    .wr_busy    (wr_busy)
);

// File: tb/sim_adc_result_port.sv
// Directed bench for the converter serial result port.
module sim_adc_result_port;

    localparam int RES_W     = 20;
    localparam int WR_STEP   = 2;
    localparam int PULSE_CYC = 8;
    localparam int HOLD_CYC  = 6;
    localparam int WARMUP    = 5;
    localparam int WR_CYC    = RES_W * WR_STEP;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       cs_mode = 2'd0;
    logic             res_strobe = 1'b0;
    logic [RES_W-1:0] res_word = '0;
    logic             cs_n = 1'b1;
    logic             sclk = 1'b0;
    logic             dout, dout_oe, drdy_n, result_ok;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    adc_result_port #(
        .RES_W(RES_W), .WR_STEP(WR_STEP), .PULSE_CYC(PULSE_CYC),
        .HOLD_CYC(HOLD_CYC), .WARMUP(WARMUP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cs_mode(cs_mode), .res_strobe(res_strobe),
        .res_word(res_word), .cs_n(cs_n), .sclk(sclk), .dout(dout),
        .dout_oe(dout_oe), .drdy_n(drdy_n), .result_ok(result_ok)
    );

    always #10 clk = ~clk;

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] mode);
        @(negedge clk);
        rst_n = 1'b0; cs_mode = mode; cs_n = 1'b1; sclk = 1'b0; res_strobe = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic select(input logic v);
        @(negedge clk);
        cs_n = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic load(input logic [RES_W-1:0] w);
        @(negedge clk);
        res_strobe = 1'b1; res_word = w;
        @(negedge clk);
        res_strobe = 1'b0;
    endtask

    task automatic load_wait(input logic [RES_W-1:0] w);
        load(w);
        repeat (WR_CYC + PULSE_CYC + 6) @(negedge clk);
    endtask

    task automatic read_bits(input int n, output logic [31:0] v);
        v = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            v = {v[30:0], dout};
            sclk = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    // Reset levels in two strap settings (R10).
    task automatic t_reset();
        do_reset(2'd0);
        check_eq("R10 drdy_n idle mode0", 32'(drdy_n), 32'd1);
        check_eq("R10 dout_oe", 32'(dout_oe), 32'd0);
        check_eq("R10 dout", 32'(dout), 32'd0);
        check_eq("R10 result_ok", 32'(result_ok), 32'd0);
        do_reset(2'd2);
        check_eq("R10 drdy_n idle mode2", 32'(drdy_n), 32'd0);
    endtask

    // Full-word reads of extreme and mixed codes (R1).
    task automatic t_readout();
        logic [RES_W-1:0] pats [4];
        logic [31:0] v;
        pats[0] = 20'h7FFFF; pats[1] = 20'h00000; pats[2] = 20'h80000; pats[3] = 20'hA5C3E;
        do_reset(2'd0);
        select(1'b0);
        for (int k = 0; k < 4; k++) begin
            load_wait(pats[k]);
            read_bits(RES_W, v);
            check_eq("R1 word readout", v, 32'(pats[k]));
        end
    endtask

    // Output enable follows chip select (R2).
    task automatic t_oe();
        do_reset(2'd0);
        select(1'b1);
        check_eq("R2 oe off", 32'(dout_oe), 32'd0);
        select(1'b0);
        check_eq("R2 oe on", 32'(dout_oe), 32'd1);
        select(1'b1);
        check_eq("R2 oe off again", 32'(dout_oe), 32'd0);
    endtask

    // Over-long read pads with zeros (R3).
    task automatic t_pad();
        logic [31:0] v;
        do_reset(2'd0);
        select(1'b0);
        load_wait(20'hFFFFF);
        read_bits(24, v);
        check_eq("R3 24-bit read", v, 32'h00FFFFF0);
    endtask

    // Partial reads followed by a new result restart at its MSB (R4).
    task automatic t_rearm();
        logic [31:0] v;
        do_reset(2'd0);
        select(1'b0);
        load_wait(20'h12345);
        read_bits(8, v);
        check_eq("R4 first 8 bits", v, 32'h12);
        load_wait(20'h9ABCD);
        read_bits(RES_W, v);
        check_eq("R4 after 8-bit read", v, 32'h9ABCD);
        load_wait(20'h3C5A1);
        read_bits(16, v);
        check_eq("R4 first 16 bits", v, 32'h3C5A);
        load_wait(20'h6E0F7);
        read_bits(RES_W, v);
        check_eq("R4 after 16-bit read", v, 32'h6E0F7);
    endtask

    // Select tied low: delay and pulse width (R5, R6).
    task automatic t_mode_low();
        int c;
        int w;
        do_reset(2'd0);
        select(1'b0);
        load(20'h0F0F0);
        c = 0;
        while (drdy_n && c < 1000) begin @(negedge clk); c++; end
        check_eq("R5 ready delay mode0", 32'(c), 32'(WR_CYC + 1));
        w = 0;
        while (!drdy_n && w < 1000) begin @(negedge clk); w++; end
        check_eq("R6 pulse width", 32'(w), 32'(PULSE_CYC));
    endtask

    // Select used per transfer: hold while deselected, release after select (R7).
    task automatic t_mode_used();
        int c;
        int bad;
        logic [31:0] v;
        do_reset(2'd1);
        load(20'h4B2D1);
        c = 0;
        while (drdy_n && c < 1000) begin @(negedge clk); c++; end
        check_eq("R5 ready delay mode1", 32'(c), 32'(WR_CYC + 1));
        bad = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (drdy_n) bad++;
        end
        check_eq("R7 held low while deselected", 32'(bad), 32'd0);
        cs_n = 1'b0;
        c = 0;
        while (!drdy_n && c < 1000) begin @(negedge clk); c++; end
        check_eq("R7 release after select", 32'(c), 32'(PULSE_CYC + 3));
        read_bits(RES_W, v);
        check_eq("R7 word after release", v, 32'h4B2D1);
    endtask

    // Select parked high: inverted idle and high window (R8).
    task automatic t_mode_high();
        int c;
        do_reset(2'd2);
        check_eq("R8 idle low", 32'(drdy_n), 32'd0);
        load(20'h11111);
        check_eq("R8 high after strobe", 32'(drdy_n), 32'd1);
        c = 0;
        while (drdy_n && c < 1000) begin @(negedge clk); c++; end
        check_eq("R8 high window", 32'(c), 32'(WR_CYC + 1 + HOLD_CYC));
    endtask

    // Warm-up results are flagged (R9).
    task automatic t_warmup();
        do_reset(2'd0);
        for (int k = 1; k <= WARMUP + 2; k++) begin
            load_wait(20'(k));
            check_eq($sformatf("R9 ok after result %0d", k), 32'(result_ok),
                     32'(k > WARMUP));
        end
    endtask

    initial begin
        t_reset();
        t_readout();
        t_oe();
        t_pad();
        t_rearm();
        t_mode_low();
        t_mode_used();
        t_mode_high();
        t_warmup();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule